// File: doc/BRIEF.md
# Retirement-Based Stall Cycle Accountant

This block keeps performance counts for an out-of-order core. Each clock cycle the core reports how many instructions retired, the retire width it is set up for, and the stall class of the oldest instruction that was still waiting. The block splits that cycle into two parts. The retired fraction goes to a busy counter. The unused fraction goes to the counter of the reported stall class. Cycles marked idle are not counted.

Fractions are held in fixed point, where one unit is one retire slot. An active cycle therefore adds exactly the effective width in slots, spread over all counters together. Software divides a counter by the width to get cycles.

The block has eleven saturating counters: one for busy time and ten for stall classes. They are read through a combinational address/data port. A synchronous clear input zeroes them all. A retire count larger than the width is clamped to the width and reported on an error output.

Top module: `stall_acct`

## Requirements
- R1: After reset every counter reads zero and `overrun_o` is low.
- R2: On each active cycle, the busy counter (read address 0) grows by the retire count, clamped to the effective width.
- R3: On each active cycle, the counter of the reported stall class grows by the effective width minus the clamped retire count. No other stall counter changes.
- R4: The sum of all counters grows by exactly the effective width on every active cycle that does not saturate.
- R5: When the clamped retire count equals the effective width, no stall counter changes.
- R6: While `active_i` is low, no counter changes and `overrun_o` is low on the next cycle.
- R7: The stall class codes are 0 CPU/functional unit, 1 write, 2 synchronization, 3 instruction fetch (cache or TLB), 4 L1 hit plus misc, 5 L2 hit, 6 local memory, 7 remote memory, 8 dirty cache-to-cache, 9 data TLB. Class c is read at address c+1. Codes 10 to 15 are charged to class 0.
- R8: A configured width of 0, or of more than MAX_RETIRE, is treated as MAX_RETIRE.
- R9: On an active cycle where the retire count exceeds the effective width, the count is clamped and `overrun_o` is high during the following cycle. Otherwise `overrun_o` is low.
- R10: When `clear_i` is asserted, every counter reads zero in the next cycle. Clear takes priority over accumulation in the same cycle.
- R11: Counters saturate at 2^ACC_W-1 and never wrap.
- R12: `rd_data_o` shows the counter at `rd_addr_i` combinationally. Addresses 11 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all counters |
| active_i | input | 1 | Cycle is counted (low means idle) |
| retire_i | input | CNT_W | Instructions retired this cycle |
| cfg_width_i | input | CNT_W | Configured maximum retire width |
| stall_cat_i | input | 4 | Stall class of the oldest unretired instruction |
| rd_addr_i | input | 4 | Counter select |
| rd_data_o | output | ACC_W | Selected counter value |
| overrun_o | output | 1 | Retire count exceeded width on the previous cycle |

## Verification
The assertions check the following on every cycle:
- the busy and stall increments always add up to the effective width;
- the class decode always selects exactly one counter;
- counters never decrease except on clear, and a clear zeroes them;
- idle cycles and fully retired cycles leave the relevant counters unchanged;
- an overrun is always flagged on the following cycle.

Only the bench scenarios can show the following:
- that the right counter is charged for every class code, including the codes folded into class 0;
- the exact slot totals after long random runs;
- the saturation value;
- the read port's handling of out-of-range addresses.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;
   localparam int CAT_W         = 4;
   localparam int NUM_STALL_CAT = 10;
   localparam int NUM_ACC       = NUM_STALL_CAT + 1;
   localparam int ADDR_W        = $clog2(NUM_ACC);

   typedef enum logic [CAT_W-1:0] {
      SC_CPU    = 4'd0,
      SC_WRITE  = 4'd1,
      SC_SYNC   = 4'd2,
      SC_IFETCH = 4'd3,
      SC_L1MISC = 4'd4,
      SC_L2HIT  = 4'd5,
      SC_LOCMEM = 4'd6,
      SC_REMMEM = 4'd7,
      SC_DIRTY  = 4'd8,
      SC_DTLB   = 4'd9
   } stall_cat_e;
endpackage

// File: rtl/sacct_decode.sv
module sacct_decode
   import stall_acct_pkg::*;
#(
   parameter int NCAT = NUM_STALL_CAT
) (
   input  logic [CAT_W-1:0] code_i,
   output logic [NCAT-1:0]  sel_o
);
   if (NCAT < 1 || NCAT > (1 << CAT_W)) begin : g_bad_ncat
      $error("sacct_decode: NCAT out of range");
   end

   // R7: unknown codes fold into class 0
   for (genvar i = 0; i < NCAT; i++) begin : g_sel
      if (i == 0) begin : g_fold
         assign sel_o[i] = (code_i == CAT_W'(0)) || (code_i >= CAT_W'(NCAT));
      end else begin : g_exact
         assign sel_o[i] = (code_i == CAT_W'(i));
      end
   end

   always_comb begin
      a_r7_onehot_sel: assert ($onehot(sel_o)) else $error("decode select not one-hot");
   end
endmodule

// File: rtl/sacct_split.sv
module sacct_split #(
   parameter int MAX_RETIRE = 8,
   parameter int CNT_W      = $clog2(MAX_RETIRE + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             active_i,
   input  logic [CNT_W-1:0] retire_i,
   input  logic [CNT_W-1:0] cfg_width_i,
   output logic [CNT_W-1:0] eff_width_o,
   output logic [CNT_W-1:0] busy_units_o,
   output logic [CNT_W-1:0] stall_units_o,
   output logic             overrun_o
);
   localparam logic [CNT_W-1:0] MAXW = CNT_W'(MAX_RETIRE);

   if (MAX_RETIRE < 1) begin : g_bad_max
      $error("sacct_split: MAX_RETIRE must be at least 1");
   end
   if ((1 << CNT_W) <= MAX_RETIRE) begin : g_bad_cnt
      $error("sacct_split: CNT_W too narrow for MAX_RETIRE");
   end

   logic too_many;

   always_comb begin
      // R8: out-of-range configuration falls back to full width
      if (cfg_width_i == '0 || cfg_width_i > MAXW) eff_width_o = MAXW;
      else                                         eff_width_o = cfg_width_i;
      too_many      = (retire_i > eff_width_o);
      busy_units_o  = too_many ? eff_width_o : retire_i;
      stall_units_o = eff_width_o - busy_units_o;
      overrun_o     = active_i && too_many;
   end

   a_r4_slots_conserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_units_o + stall_units_o) == eff_width_o);
   a_r8_width_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eff_width_o >= CNT_W'(1)) && (eff_width_o <= MAXW));
endmodule

// File: rtl/sacct_acc.sv
module sacct_acc #(
   parameter int ACC_W = 32,
   parameter int INC_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [ACC_W-1:0] acc_o
);
   if (ACC_W <= INC_W) begin : g_bad_acc
      $error("sacct_acc: ACC_W must exceed INC_W");
   end

   logic [ACC_W:0] sum;
   assign sum = {1'b0, acc_o} + (ACC_W + 1)'(inc_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      acc_o <= '0;
      else if (clr_i)   acc_o <= '0;
      else if (en_i)    acc_o <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
   end

   a_r10_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (acc_o == '0));
   a_r11_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (acc_o >= $past(acc_o)));
   a_r6_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !en_i) |=> $stable(acc_o));
endmodule

// File: rtl/stall_acct.sv
module stall_acct
   import stall_acct_pkg::*;
#(
   parameter int MAX_RETIRE = 8,
   parameter int ACC_W      = 32,
   localparam int CNT_W     = $clog2(MAX_RETIRE + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              active_i,
   input  logic [CNT_W-1:0]  retire_i,
   input  logic [CNT_W-1:0]  cfg_width_i,
   input  logic [CAT_W-1:0]  stall_cat_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [ACC_W-1:0]  rd_data_o,
   output logic              overrun_o
);
   logic [CNT_W-1:0]              eff_w, busy_u, stall_u;
   logic                          ovr_now;
   logic [NUM_STALL_CAT-1:0]      cat_sel;
   logic [NUM_ACC-1:0][ACC_W-1:0] acc_q;

   sacct_split #(.MAX_RETIRE(MAX_RETIRE), .CNT_W(CNT_W)) u_split (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .active_i     (active_i),
      .retire_i     (retire_i),
      .cfg_width_i  (cfg_width_i),
      .eff_width_o  (eff_w),
      .busy_units_o (busy_u),
      .stall_units_o(stall_u),
      .overrun_o    (ovr_now)
   );

   sacct_decode #(.NCAT(NUM_STALL_CAT)) u_dec (
      .code_i(stall_cat_i),
      .sel_o (cat_sel)
   );

   // slot 0 is busy time, slot c+1 is stall class c
   for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
      logic             en;
      logic [CNT_W-1:0] inc;
      if (i == 0) begin : g_busy
         assign en  = active_i;
         assign inc = busy_u;
      end else begin : g_stall
         assign en  = active_i && cat_sel[i-1];
         assign inc = stall_u;
      end
      sacct_acc #(.ACC_W(ACC_W), .INC_W(CNT_W)) u_acc (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .clr_i (clear_i),
         .en_i  (en),
         .inc_i (inc),
         .acc_o (acc_q[i])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) overrun_o <= 1'b0;
      else         overrun_o <= ovr_now;
   end

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NUM_ACC; k++) begin
         if (rd_addr_i == ADDR_W'(k)) rd_data_o = acc_q[k];
      end
   end

   a_r9_overrun_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && (retire_i > eff_w)) |=> overrun_o);
   a_r6_idle_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i |=> !overrun_o);
   a_r5_full_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && !clear_i && (retire_i >= eff_w)) |=> $stable(acc_q[NUM_ACC-1:1]));
endmodule

// File: tb/stall_acct_tb.sv
module stall_acct_tb;
   localparam int CLK_PERIOD = 40;
   localparam int MAXR       = 8;
   localparam int AW         = 12;
   localparam longint SATV   = (64'd1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic          active = 1'b0;
   logic [3:0]    retire = '0;
   logic [3:0]    cfgw = 4'd8;
   logic [3:0]    cat = '0;
   logic [3:0]    rd_addr = '0;
   logic [AW-1:0] rd_data;
   logic          overrun;

   int     n_chk = 0;
   int     n_fail = 0;
   bit     finished = 0;
   longint model [11];
   longint prev_sum = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stall_acct #(.MAX_RETIRE(MAXR), .ACC_W(AW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .active_i(active),
      .retire_i(retire), .cfg_width_i(cfgw), .stall_cat_i(cat),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .overrun_o(overrun));

   function automatic int eff_of(input int w);
      return (w == 0 || w > MAXR) ? MAXR : w;
   endfunction

   function automatic longint sat_add(input longint a, input longint b);
      return (a + b > SATV) ? SATV : a + b;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // read every address, compare against model, return sum of counters
   task automatic compare_all(input string tag, output longint dsum);
      bit ok = 1;
      longint bad_a = 0, bad_e = 0;
      dsum = 0;
      for (int a = 0; a < 16; a++) begin
         longint e;
         rd_addr = 4'(a);
         #1;
         e = (a < 11) ? model[a] : 0;
         if (a < 11) dsum += longint'(rd_data);
         if (longint'(rd_data) != e && ok) begin
            ok = 0; bad_a = longint'(rd_data); bad_e = e;
         end
      end
      check(ok, tag, bad_a, bad_e);
   endtask

   task automatic step(input bit act, input int ret, input int w, input int c,
                       input bit clr, input string tag, input bit do_cmp);
      int eff, r, idx;
      bit exp_ovr;
      longint dsum;
      bit sum_ok_case;
      @(negedge clk);
      active = act; retire = 4'(ret); cfgw = 4'(w); cat = 4'(c); clear = clr;
      @(posedge clk);
      eff = eff_of(w);
      r = (ret > eff) ? eff : ret;
      exp_ovr = act && (ret > eff);
      sum_ok_case = act && !clr;
      for (int k = 0; k < 11; k++) if (model[k] > SATV - 16) sum_ok_case = 0;
      if (clr) begin
         for (int k = 0; k < 11; k++) model[k] = 0;
      end else if (act) begin
         idx = ((c > 9) ? 0 : c) + 1;
         model[0] = sat_add(model[0], r);
         model[idx] = sat_add(model[idx], eff - r);
      end
      #1;
      check(overrun == exp_ovr, "R9 overrun flag", overrun, exp_ovr);
      if (do_cmp) begin
         compare_all(tag, dsum);
         if (sum_ok_case)
            check(dsum - prev_sum == eff, "R4 slot total", dsum - prev_sum, eff);
         prev_sum = dsum;
      end
   endtask

   initial begin
      longint s;
      for (int k = 0; k < 11; k++) model[k] = 0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check(overrun == 1'b0, "R1 reset overrun", overrun, 0);
      compare_all("R1 reset counters", s);
      rst_n = 1'b1;
      compare_all("R1 after release", s);
      prev_sum = s;

      step(1, 3, 8, 5, 0, "R2 R3 partial retire", 1);
      step(1, 8, 8, 7, 0, "R5 full retire", 1);
      step(0, 2, 8, 1, 0, "R6 idle cycle", 1);
      for (int c = 0; c < 16; c++) step(1, 1, 4, c, 0, "R7 class decode", 1);
      step(1, 2, 0, 2, 0, "R8 width zero", 1);
      step(1, 2, 13, 3, 0, "R8 width too large", 1);
      step(1, 11, 4, 6, 0, "R9 retire above width", 1);
      step(1, 1, 4, 6, 0, "R9 flag drops", 1);
      step(0, 15, 2, 6, 0, "R6 idle overrun ignored", 1);
      step(1, 4, 8, 8, 1, "R10 clear wins", 1);
      compare_all("R12 read after clear", s);

      for (int i = 0; i < 300; i++) begin
         int a = ($urandom % 8 != 0);
         int w = $urandom % 10;
         int r = $urandom % 10;
         int c = $urandom % 16;
         step(a[0], r, w, c, 0, "R2 R3 random mix", 1);
      end

      step(1, 0, 8, 0, 1, "R10 clear before saturation", 1);
      for (int i = 0; i < 520; i++) step(1, 8, 8, 4, 0, "R11", 0);
      for (int i = 0; i < 520; i++) step(1, 0, 8, 9, 0, "R11", 0);
      step(1, 8, 8, 4, 0, "R11 saturated counters", 1);
      rd_addr = 4'd0;
      #1;
      check(longint'(rd_data) == SATV, "R11 busy at ceiling", rd_data, SATV);
      rd_addr = 4'd15;
      #1;
      check(rd_data == '0, "R12 unused address", rd_data, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule